// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Scoped Invalidation

This block is a small fully associative translation cache. Each slot stores a valid bit, a 12-bit context tag, a virtual page number, a physical page number and a global flag. A combinational lookup port takes the current context and a linear address. It answers with a hit flag and the physical page of the matching slot. A fill port writes one translation per cycle. A fill whose context and page match a live slot rewrites that slot. Otherwise the fill goes to the lowest free slot, or, when every slot is live, to the slot named by a rotating victim pointer.

An invalidation port takes an operation code and a 128-bit descriptor. The descriptor carries the context tag in bits [11:0] and a linear address in bits [127:64]. Bits [63:12] of the descriptor must be zero. The low two bits of the code choose the scope:
- 0: one page of one context.
- 1: one whole context.
- 2: everything, global slots included.
- 3: everything except global slots, with the descriptor ignored.

The scrub acts on all slots in one clock edge. A completion pulse follows one cycle later, or an error pulse if the descriptor was refused.

Top module: `ctx_tlb`

## Requirements
- R1: A synchronous active-high reset empties every slot and drops the completion and error pulses, so every lookup afterwards misses.
- R2: A lookup hits when a valid slot has the looked-up page (address bits above bit 11) and either its context equals the current context or its global flag is 1; lk_ppn then gives that slot's physical page.
- R3: A fill whose context and page equal those of a valid slot rewrites that slot's physical page and global flag in place.
- R4: A fill with no such match uses the lowest-numbered free slot. If no slot is free, it replaces the slot at a round-robin pointer that starts at 0 after reset and advances by one on each replacement.
- R5: Code 0 removes non-global slots whose context equals descriptor bits [11:0] and whose page equals the page of descriptor bits [127:64].
- R6: Code 1 removes every non-global slot whose context equals descriptor bits [11:0].
- R7: Code 2 removes every slot, global ones included.
- R8: Code 3 removes every non-global slot and ignores the descriptor entirely, reserved bits included.
- R9: Only bits [1:0] of the 8-bit operation code select the operation; bits [7:2] have no effect.
- R10: For codes 0 to 2, a descriptor with any of bits [63:12] set is refused. inv_err pulses for one cycle, inv_done stays low, and no slot changes.
- R11: An accepted invalidation raises inv_done for exactly the next cycle, and lookups made in that cycle already see the scrubbed contents.
- R12: In a cycle with inv_en high, a fill request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pcid | input | PCID_W | Current context for lookup |
| lk_addr | input | VA_W | Linear address to translate |
| lk_hit | output | 1 | Lookup found a translation |
| lk_ppn | output | PPN_W | Physical page of the hit, zero on miss |
| fill_en | input | 1 | Write a translation this cycle |
| fill_pcid | input | PCID_W | Context of the new translation |
| fill_vpn | input | VA_W-PAGE_SHIFT | Virtual page of the new translation |
| fill_ppn | input | PPN_W | Physical page of the new translation |
| fill_glb | input | 1 | New translation is global |
| inv_en | input | 1 | Issue an invalidation this cycle |
| inv_op | input | 8 | Operation code, low two bits used |
| inv_desc | input | 128 | Descriptor: context [11:0], reserved [63:12], address [127:64] |
| inv_done | output | 1 | One-cycle pulse after an accepted invalidation |
| inv_err | output | 1 | One-cycle pulse after a refused descriptor |

## Verification
The properties assume that inv_en is a one-cycle command whose operands are steady at the sampling edge. They also assume that the descriptor address field carries a page that fits the configured address width. The stimulus drives every command and fill on the falling edge and holds it for exactly one cycle. It builds each descriptor from a page that fits the address width, so the upper address bits are always zero. Fills and invalidations coincide only in the one directed case that exercises the drop rule.

// File: rtl/ctx_tlb.sv
module ctx_tlb #(
  parameter int ENTRIES    = 8,
  parameter int PCID_W     = 12,
  parameter int VA_W       = 48,
  parameter int PAGE_SHIFT = 12,
  parameter int PPN_W      = 24
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PCID_W-1:0]          lk_pcid,
  input  logic [VA_W-1:0]            lk_addr,
  output logic                       lk_hit,
  output logic [PPN_W-1:0]           lk_ppn,
  input  logic                       fill_en,
  input  logic [PCID_W-1:0]          fill_pcid,
  input  logic [VA_W-PAGE_SHIFT-1:0] fill_vpn,
  input  logic [PPN_W-1:0]           fill_ppn,
  input  logic                       fill_glb,
  input  logic                       inv_en,
  input  logic [7:0]                 inv_op,
  input  logic [127:0]               inv_desc,
  output logic                       inv_done,
  output logic                       inv_err
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, glb, kill;
  logic [PCID_W-1:0]  e_pcid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn  [ENTRIES];
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic [IDX_W-1:0]   victim, hit_idx, free_idx, wr_idx;
  logic               hit_any, free_any;

  wire [1:0]        kind     = inv_op[1:0];
  wire [PCID_W-1:0] d_pcid   = inv_desc[PCID_W-1:0];
  wire [VPN_W-1:0]  d_vpn    = inv_desc[64+PAGE_SHIFT +: VPN_W];
  wire              rsv_bad  = (kind != 2'd3) && (|inv_desc[63:12]);
  wire [VPN_W-1:0]  lk_vpn   = lk_addr[VA_W-1:PAGE_SHIFT];

  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = ENTRIES-1; i >= 0; i--)
      if (vld[i] && e_vpn[i] == lk_vpn && (glb[i] || e_pcid[i] == lk_pcid)) begin
        lk_hit = 1'b1;
        lk_ppn = e_ppn[i];
      end
  end

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (vld[i] && e_pcid[i] == fill_pcid && e_vpn[i] == fill_vpn) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    wr_idx = hit_any ? hit_idx : (free_any ? free_idx : victim);
  end

  always_comb
    for (int i = 0; i < ENTRIES; i++)
      case (kind)
        2'd0:    kill[i] = !glb[i] && e_pcid[i] == d_pcid && e_vpn[i] == d_vpn;
        2'd1:    kill[i] = !glb[i] && e_pcid[i] == d_pcid;
        2'd2:    kill[i] = 1'b1;
        default: kill[i] = !glb[i];
      endcase

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      victim   <= '0;
      inv_done <= 1'b0;
      inv_err  <= 1'b0;
    end else begin
      inv_done <= inv_en && !rsv_bad;
      inv_err  <= inv_en && rsv_bad;
      if (inv_en) begin
        if (!rsv_bad) vld <= vld & ~kill;
      end else if (fill_en) begin
        vld[wr_idx] <= 1'b1;
        if (!hit_any && !free_any)
          victim <= (victim == IDX_W'(ENTRIES-1)) ? '0 : victim + 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst && !inv_en && fill_en) begin
      glb[wr_idx]    <= fill_glb;
      e_pcid[wr_idx] <= fill_pcid;
      e_vpn[wr_idx]  <= fill_vpn;
      e_ppn[wr_idx]  <= fill_ppn;
    end

  // R11
  done_after_inv_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en && !rsv_bad |=> inv_done && !inv_err);

  // R11
  no_stray_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !inv_en |=> !inv_done && !inv_err);

  // R10
  refused_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en && rsv_bad |=> inv_err && !inv_done && $stable(vld));

  // R7
  all_gone_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en && !rsv_bad && kind == 2'd2 |=> vld == '0);

  // R8
  glb_only_chk: assert property (@(posedge clk) disable iff (rst)
    inv_en && kind == 2'd3 |=> (vld & ~glb) == '0);
endmodule

// File: tb/tb_ctx_tlb.sv
module tb_ctx_tlb;
  localparam int PCID_W = 12, VA_W = 48, PS = 12, PPN_W = 24, VPN_W = VA_W - PS;

  logic clk = 1'b0, rst = 1'b1;
  logic [PCID_W-1:0] lk_pcid = '0, fill_pcid = '0;
  logic [VA_W-1:0]   lk_addr = '0;
  logic              lk_hit, fill_en = 1'b0, fill_glb = 1'b0, inv_en = 1'b0;
  logic [PPN_W-1:0]  lk_ppn, fill_ppn = '0;
  logic [VPN_W-1:0]  fill_vpn = '0;
  logic [7:0]        inv_op = '0;
  logic [127:0]      inv_desc = '0;
  logic              inv_done, inv_err;
  int total = 0, bad = 0;

  ctx_tlb dut (.*);

  always #2 clk = ~clk;

  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] pcid;
    logic [15:0] vpn;
    logic [15:0] ppn;
    logic        glb;
    logic [1:0]  typ;
    logic        eh;
    logic [15:0] ep;
  } step_t;

  localparam int NSTEP = 26;
  localparam step_t STEPS [NSTEP] = '{
    '{2'd0, 12'd1, 16'h10, 16'hA1, 1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd0, 12'd2, 16'h10, 16'hB2, 1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd0, 12'd1, 16'h20, 16'hC3, 1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd0, 12'd5, 16'h30, 16'hD4, 1'b1, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd1, 16'h10, 16'h0,  1'b0, 2'd0, 1'b1, 16'hA1},
    '{2'd2, 12'd2, 16'h10, 16'h0,  1'b0, 2'd0, 1'b1, 16'hB2},
    '{2'd2, 12'd3, 16'h10, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd3, 16'h30, 16'h0,  1'b0, 2'd0, 1'b1, 16'hD4},
    '{2'd0, 12'd1, 16'h10, 16'hE5, 1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd1, 16'h10, 16'h0,  1'b0, 2'd0, 1'b1, 16'hE5},
    '{2'd1, 12'd1, 16'h10, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd1, 16'h10, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd1, 16'h20, 16'h0,  1'b0, 2'd0, 1'b1, 16'hC3},
    '{2'd2, 12'd2, 16'h10, 16'h0,  1'b0, 2'd0, 1'b1, 16'hB2},
    '{2'd1, 12'd5, 16'h30, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd5, 16'h30, 16'h0,  1'b0, 2'd0, 1'b1, 16'hD4},
    '{2'd1, 12'd1, 16'h0,  16'h0,  1'b0, 2'd1, 1'b0, 16'h0},
    '{2'd2, 12'd1, 16'h20, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd2, 16'h10, 16'h0,  1'b0, 2'd0, 1'b1, 16'hB2},
    '{2'd1, 12'd5, 16'h0,  16'h0,  1'b0, 2'd1, 1'b0, 16'h0},
    '{2'd2, 12'd0, 16'h30, 16'h0,  1'b0, 2'd0, 1'b1, 16'hD4},
    '{2'd1, 12'd0, 16'h0,  16'h0,  1'b0, 2'd3, 1'b0, 16'h0},
    '{2'd2, 12'd2, 16'h10, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0},
    '{2'd2, 12'd7, 16'h30, 16'h0,  1'b0, 2'd0, 1'b1, 16'hD4},
    '{2'd1, 12'd0, 16'h0,  16'h0,  1'b0, 2'd2, 1'b0, 16'h0},
    '{2'd2, 12'd5, 16'h30, 16'h0,  1'b0, 2'd0, 1'b0, 16'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_desc(input logic [11:0] p, input logic [15:0] v);
    return {64'(v) << PS, 52'b0, p};
  endfunction

  task automatic do_fill(input logic [11:0] p, input logic [15:0] v, input logic [15:0] pp, input logic g);
    @(negedge clk);
    fill_en = 1'b1; fill_pcid = p; fill_vpn = VPN_W'(v); fill_ppn = PPN_W'(pp); fill_glb = g;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_inv(input logic [7:0] op, input logic [127:0] d);
    @(negedge clk);
    inv_en = 1'b1; inv_op = op; inv_desc = d;
    @(negedge clk);
    inv_en = 1'b0;
  endtask

  task automatic look(input logic [11:0] p, input logic [15:0] v, input bit eh, input logic [15:0] ep, input string req);
    lk_pcid = p; lk_addr = {VPN_W'(v), 12'h123};
    #1;
    chk(lk_hit == eh, req, 32'(lk_hit), 32'(eh));
    if (eh) chk(lk_ppn == PPN_W'(ep), req, 32'(lk_ppn), 32'(ep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    look(12'd1, 16'h10, 1'b0, 16'h0, "R1");
    chk(!inv_done && !inv_err, "R1", 32'({inv_done, inv_err}), 0);

    // table: R2 R3 R5 R6 R7 R8 R11
    for (int k = 0; k < NSTEP; k++) begin
      case (STEPS[k].op)
        2'd0: do_fill(STEPS[k].pcid, STEPS[k].vpn, STEPS[k].ppn, STEPS[k].glb);
        2'd1: begin
          do_inv({6'b0, STEPS[k].typ}, mk_desc(STEPS[k].pcid, STEPS[k].vpn));
          chk(inv_done && !inv_err, "R11", 32'({inv_done, inv_err}), 32'h2);
        end
        default: begin
          @(negedge clk);
          look(STEPS[k].pcid, STEPS[k].vpn, STEPS[k].eh, STEPS[k].ep, "R2");
        end
      endcase
    end

    // R10 reserved bits refused
    do_fill(12'd1, 16'h40, 16'h77, 1'b0);
    do_inv(8'h00, mk_desc(12'd1, 16'h40) | (128'h1 << 20));
    chk(inv_err && !inv_done, "R10", 32'({inv_done, inv_err}), 32'h1);
    look(12'd1, 16'h40, 1'b1, 16'h77, "R10");
    @(negedge clk);
    chk(!inv_err, "R10", 32'(inv_err), 0);

    // R11 done is a single pulse and same-cycle lookup sees scrub
    do_inv(8'h01, mk_desc(12'd1, 16'h0));
    look(12'd1, 16'h40, 1'b0, 16'h0, "R11");
    @(negedge clk);
    chk(!inv_done, "R11", 32'(inv_done), 0);

    // R8 type 3 ignores reserved bits
    do_fill(12'd6, 16'h41, 16'h55, 1'b0);
    do_fill(12'd6, 16'h42, 16'h66, 1'b1);
    do_inv(8'h03, {64'hFFFF, 64'hFFFF_F000});
    chk(inv_done && !inv_err, "R8", 32'({inv_done, inv_err}), 32'h2);
    look(12'd6, 16'h41, 1'b0, 16'h0, "R8");
    look(12'd6, 16'h42, 1'b1, 16'h66, "R8");

    // R9 upper code bits ignored: 0x06 behaves as code 2
    do_inv(8'h06, 128'h0);
    chk(inv_done, "R9", 32'(inv_done), 1);
    look(12'd6, 16'h42, 1'b0, 16'h0, "R9");

    // R12 fill dropped during invalidation
    @(negedge clk);
    inv_en = 1'b1; inv_op = 8'h01; inv_desc = mk_desc(12'd9, 16'h0);
    fill_en = 1'b1; fill_pcid = 12'd3; fill_vpn = VPN_W'(16'h50); fill_ppn = 24'h99; fill_glb = 1'b0;
    @(negedge clk);
    inv_en = 1'b0; fill_en = 1'b0;
    look(12'd3, 16'h50, 1'b0, 16'h0, "R12");

    // R4 free slots then round robin
    for (int i = 0; i < 10; i++) do_fill(12'd2, 16'(16'h100 + i), 16'(16'h200 + i), 1'b0);
    look(12'd2, 16'h100, 1'b0, 16'h0, "R4");
    look(12'd2, 16'h101, 1'b0, 16'h0, "R4");
    look(12'd2, 16'h102, 1'b1, 16'h202, "R4");
    look(12'd2, 16'h109, 1'b1, 16'h209, "R4");

    // R1 reset mid-run
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    look(12'd2, 16'h109, 1'b0, 16'h0, "R1");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule